// File: doc/BRIEF.md
# Quasi-Random Test Pattern Source with Single-Bit Error Injection

This block produces a quasi-random bit stream for a T1 transmit data path, one bit per enabled clock. The stream comes from a 20-stage maximal-length shift register. A zero-run limiter forces a one whenever another zero would make more than fourteen zeros in a row, and raises a flag that marks the forced bit. The pattern bit then travels the same route as external transmit data, loopbacks included.

A test controller can request a single logic error by raising an error-request line that is asynchronous to the transmit clock. The block synchronises that line, catches its rising edge and inverts exactly one later output bit. It never spends the error on a forced bit. While the zero run sits at its limit the request waits, so an injected zero can never stretch a run past fourteen.

Top module: `qrss_gen`

## Requirements
- R1: While reset is asserted and after it is released, before the first enabled clock, `pat_out` and `forced_out` are both 0.
- R2: With no forcing and no injection, each enabled clock registers onto `pat_out` the bit s[19] XOR s[16] of a 20-bit register s. The same edge shifts that bit into s[0] (polynomial x^20 + x^17 + 1). Reset loads s = 0x00001. After reset, bits 1 to 16 of the raw sequence are 0 and bit 17 is 1.
- R3: `pat_out` never carries more than 14 consecutive zeros. When 14 zeros have been sent and the raw bit is 0, the bit sent is 1 and `forced_out` is 1 for that bit.
- R4: `forced_out` is 0 on every bit that was not forced.
- R5: While `en` is low, `pat_out`, `forced_out`, the shift register and the zero-run count all hold.
- R6: A rising edge of `err_req` while `en` is high inverts exactly one output bit. With no deferral, that is the bit registered on the third enabled rising clock edge after the first edge that samples `err_req` high.
- R7: A steady `err_req`, whether low or high, and a falling edge of `err_req` insert no error.
- R8: An injection is never applied while the zero run is at its limit, whether or not that bit is forced. The request stays pending and inverts the next bit sent below the limit.
- R9: A rising edge of `err_req` that is sampled while `en` is low is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance the pattern by one bit per clock when high |
| err_req | input | 1 | Asynchronous error request; the rising edge counts |
| pat_out | output | 1 | Pattern bit being transmitted |
| forced_out | output | 1 | High when the current bit was forced to one by the zero-run limiter |

## Verification
A wrong shift-register tap or seed shows on `pat_out` within the first 17 bits after reset, because the seed produces a 16-zero raw run. That run also tests the limiter on bits 15 and 16. A zero-run counter that is off by one shows as a forced bit one place early or late, or as a 15-zero run. A lost or doubled pending request shows as a missing or extra inverted bit a few clocks after the request edge. The bench compares every bit against a model built from these requirements, so any of these faults is caught on the first bit where it matters.

// File: rtl/qrss_gen.sv
module qrss_gen #(
  parameter int W         = 20,
  parameter int TAP       = 17,
  parameter int SEED      = 1,
  parameter int MAX_ZEROS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic err_req,
  output logic pat_out,
  output logic forced_out
);
  localparam int RW = $clog2(MAX_ZEROS + 1);

  logic [W-1:0]  sr;
  logic [RW-1:0] run;
  logic [2:0]    sy;
  logic          pend;

  wire raw    = sr[W-1] ^ sr[TAP-1];
  wire at_lim = (run == RW'(MAX_ZEROS));
  wire take   = en & pend & ~at_lim;
  wire bit_o  = at_lim ? 1'b1 : (raw ^ take);
  wire rise   = sy[1] & ~sy[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= W'(SEED);
      run        <= '0;
      sy         <= '0;
      pend       <= 1'b0;
      pat_out    <= 1'b0;
      forced_out <= 1'b0;
    end else begin
      sy   <= {sy[1:0], err_req};
      pend <= (pend & ~take) | (rise & en);
      if (en) begin
        sr         <= {sr[W-2:0], raw};
        run        <= bit_o ? '0 : run + 1'b1;
        pat_out    <= bit_o;
        forced_out <= at_lim & ~raw;
      end
    end
  end

  AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sr != '0);  // R2
  AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(MAX_ZEROS));  // R3
  AST_FORCE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    en && at_lim && !raw |=> forced_out && pat_out);  // R3
  AST_NO_FORCE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    en && !at_lim |=> !forced_out);  // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pat_out) && $stable(forced_out) && $stable(sr) && $stable(run));  // R5
  AST_TAKE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pat_out != sr[0]);  // R6
  AST_DEFER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    en && pend && at_lim |=> pend);  // R8
endmodule

// File: tb/qrss_gen_test.sv
`timescale 1ns/100ps
module qrss_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, err_req = 1'b0;
  logic pat_out, forced_out;
  int   n_chk = 0, n_bad = 0;

  logic [19:0] m_sr;
  int          m_run, m_takes, seen_run, max_run;
  logic [2:0]  m_sy;
  logic        m_pend, e_pat, e_forced;

  always #2.5 clk = ~clk;

  qrss_gen uut (.clk(clk), .rst_n(rst_n), .en(en), .err_req(err_req),
                .pat_out(pat_out), .forced_out(forced_out));

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_init();
    m_sr = 20'h00001; m_run = 0; m_sy = 3'b000; m_pend = 1'b0;
    e_pat = 1'b0; e_forced = 1'b0; m_takes = 0; seen_run = 0;
  endtask

  // one clock; model follows R2..R9 using the inputs present at the edge
  task automatic step(input string req);
    logic raw, lim, take, rise;
    @(posedge clk); #1;
    rise = m_sy[1] & ~m_sy[2];
    take = 1'b0;
    if (en) begin
      raw = m_sr[19] ^ m_sr[16];
      lim = (m_run == 14);
      take = m_pend & ~lim;
      e_pat = lim ? 1'b1 : (raw ^ take);
      e_forced = lim & ~raw;
      m_run = e_pat ? 0 : m_run + 1;
      m_sr = {m_sr[18:0], raw};
      if (take) m_takes++;
      seen_run = pat_out ? 0 : seen_run + 1;
      if (seen_run > max_run) max_run = seen_run;
    end
    m_pend = (m_pend & ~take) | (rise & en);
    m_sy = {m_sy[1:0], err_req};
    check(req, pat_out, e_pat, "pat_out");
    check(req, forced_out, e_forced, "forced_out");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; err_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", pat_out, 1'b0, "pat_out in reset");
    check("R1", forced_out, 1'b0, "forced_out in reset");
    rst_n = 1'b1;
    model_init();
    step("R1");
  endtask

  task automatic t_seed_force();
    en = 1'b1;
    for (int i = 1; i <= 17; i++) begin
      step("R2");
      if (i == 15) begin
        check("R3", pat_out, 1'b1, "bit 15 forced one");
        check("R3", forced_out, 1'b1, "bit 15 flag");
      end
      if (i == 16) check("R4", forced_out, 1'b0, "bit 16 flag");
      if (i == 17) check("R2", pat_out, 1'b1, "bit 17 raw one");
    end
  endtask

  task automatic t_limit_defer();
    en = 1'b1;
    for (int i = 1; i <= 11; i++) step("R8");
    err_req = 1'b1;
    for (int i = 12; i <= 17; i++) begin
      step("R8");
      if (i == 15) begin
        check("R8", pat_out, 1'b1, "bit 15 forced, no injection");
        check("R8", forced_out, 1'b1, "bit 15 flag");
      end
      if (i == 16) begin
        check("R8", pat_out, 1'b1, "deferred error on bit 16");
        check("R8", forced_out, 1'b0, "bit 16 flag");
      end
    end
    err_req = 1'b0;
    check("R8", (m_takes == 1), 1'b1, "one deferred injection");
  endtask

  task automatic t_free_run(input int n);
    en = 1'b1;
    for (int i = 0; i < n; i++) step("R2");
    check("R3", (max_run <= 14), 1'b1, "longest zero run");
  endtask

  task automatic t_hold();
    logic p, f;
    en = 1'b0;
    p = pat_out; f = forced_out;
    for (int i = 0; i < 10; i++) step("R5");
    check("R5", pat_out, p, "pat_out held");
    check("R5", forced_out, f, "forced_out held");
    en = 1'b1;
    for (int i = 0; i < 40; i++) step("R5");
  endtask

  task automatic t_single_inject();
    int t0;
    en = 1'b1; t0 = m_takes;
    err_req = 1'b1;
    for (int i = 0; i < 20; i++) step("R6");
    check("R6", (m_takes - t0 == 1), 1'b1, "exactly one inversion");
    err_req = 1'b0;
    for (int i = 0; i < 20; i++) step("R7");
    check("R7", (m_takes - t0 == 1), 1'b1, "falling edge no inversion");
  endtask

  task automatic t_level();
    int t0;
    en = 1'b1;
    for (int i = 0; i < 60; i++) step("R7");
    t0 = m_takes;
    for (int i = 0; i < 60; i++) step("R7");
    check("R7", (m_takes == t0), 1'b1, "steady low no inversion");
  endtask

  task automatic t_disabled_edge();
    int t0;
    t0 = m_takes;
    en = 1'b0; err_req = 1'b1;
    for (int i = 0; i < 6; i++) step("R9");
    en = 1'b1;
    for (int i = 0; i < 30; i++) step("R9");
    err_req = 1'b0;
    for (int i = 0; i < 10; i++) step("R9");
    check("R9", (m_takes == t0), 1'b1, "edge while disabled discarded");
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    max_run = 0;
    t_reset();
    t_seed_force();
    t_reset();
    t_limit_defer();
    t_free_run(600);
    t_hold();
    t_single_inject();
    t_level();
    t_disabled_edge();
    t_free_run(300);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule